// File: doc/BRIEF.md
# Gain-Indexed Cascaded Biquad Equalizer

This block shapes a slow, single-channel biosignal stream with a four-band graphic equalizer. Each band is one second-order recursive section. Software sets a gain in whole decibels for each band. That gain selects the band's five coefficients from a table built into the block. Software never writes coefficients. Each accepted sample passes through band 0, then band 1, band 2 and band 3, and every section's output is the next section's input.

One signed multiply-accumulate unit does all the arithmetic. It works through five products per section and four sections per sample, so a result appears a fixed number of cycles after each input. The stream arrives at about 1 kHz, so the core clock leaves many idle cycles between samples. Gains written to the register port are held aside and only take effect when the next sample is accepted. Section history survives gain changes, so the output moves to the new response without a jump back to zero.

Top module: `biquad_eq_top`

## Requirements
- R1: `in_data` is a 12-bit two's-complement sample and is sign-extended to 16 bits. `out_data` is a 16-bit two's-complement result.
- R2: A cycle with `reg_we` high writes `reg_wdata` to band `reg_addr` (0 to 3). `reg_wdata` is read as a 5-bit signed dB value and is clamped to the range -9 to +9.
- R3: Coefficients are in Q2.14. A band with constants (P, Q, S) at gain g uses taps in the order b0 = 16384 + g·S, b1 = P, b2 = Q − g·S, a1 = P, a2 = Q. The table row is g + 9. The band constants are: band 0 (−30364, 15416, 1000), band 1 (−21917, 15099, 800), band 2 (−5291, 14787, 600), band 3 (18127, 14477, 500).
- R4: Each section computes acc = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2 in direct form I. Here x1 and x2 are its past inputs and y1 and y2 are its past outputs. The result is acc shifted right arithmetically by 14 bits.
- R5: The four sections run in series in band order 0, 1, 2, 3. The output of section k is the input of section k+1, and `out_data` is the output of section 3.
- R6: With every band at 0 dB and zero history, `out_data` equals the sign-extended input exactly.
- R7: A sample is accepted at a rising edge where `in_valid` is high and the block is idle. `out_valid` is then high for exactly one cycle, starting at the 20th rising edge after the accepting edge.
- R8: `in_valid` asserted while a sample is being processed is ignored. It produces no extra result and leaves later results unchanged.
- R9: Gains written while a sample is being processed do not affect that sample. They apply from the next accepted sample on, and section history is not cleared.
- R10: Synchronous active-low reset clears `out_valid`, `out_data`, all band gains (to 0 dB) and all section history.
- R11: Every section result saturates to the range −32768 to +32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Signed equalized sample |
| reg_we | input | 1 | Gain register write enable |
| reg_addr | input | 2 | Band selected for the write |
| reg_wdata | input | 5 | Signed gain in dB |

## Verification
An all-zero-gain sweep over the whole 12-bit input range tells exact unity pass-through apart from any rounding or sign-extension slip. An impulse followed by a short tail is sent at each gain of each band. This separates the table rows from each other and catches tap ordering, the subtraction of the feedback terms and a wrong cascade order. Three further patterns probe the boundaries. Out-of-range gain writes expose a missing clamp. A write or a stray strobe during processing separates sample-boundary gain latching from immediate use. A resonant square wave at full gain drives the sections into saturation, which a wrapping implementation would get wrong.

// File: rtl/eq_pkg.sv
// Shared constants, state type and coefficient formula for the equalizer.
// Assumes exactly four bands of one biquad section each, five taps per section.
package eq_pkg;

    localparam int EQ_BANDS  = 4;
    localparam int EQ_TAPS   = 5;
    localparam int EQ_BAND_W = $clog2(EQ_BANDS);
    localparam int EQ_TAP_W  = $clog2(EQ_TAPS);

    typedef enum logic {EQ_IDLE, EQ_RUN} eq_state_e;

    // Feedback term a1 of each band (Q2.14)
    function automatic int pole_a1(input int band);
        case (band)
            0:       return -30364;
            1:       return -21917;
            2:       return -5291;
            default: return 18127;
        endcase
    endfunction

    // Feedback term a2 of each band (Q2.14)
    function automatic int pole_a2(input int band);
        case (band)
            0:       return 15416;
            1:       return 15099;
            2:       return 14787;
            default: return 14477;
        endcase
    endfunction

    // Numerator change per dB of gain for each band (Q2.14)
    function automatic int gain_step(input int band);
        case (band)
            0:       return 1000;
            1:       return 800;
            2:       return 600;
            default: return 500;
        endcase
    endfunction

    // Tap value: 0:b0 1:b1 2:b2 3:a1 4:a2, scale already folded into b terms
    function automatic int coef_val(input int band, input int gain, input int tap, input int one);
        int d;
        d = gain * gain_step(band);
        case (tap)
            0:       return one + d;
            1:       return pole_a1(band);
            2:       return pole_a2(band) - d;
            3:       return pole_a1(band);
            default: return pole_a2(band);
        endcase
    endfunction

endpackage

// File: rtl/eq_gain_regs.sv
// Band gain registers: a shadow copy written by the register port (clamped
// to +/-GAIN_LIM) and an active copy loaded only at a sample boundary.
// Assumes reg_addr always names an existing band.
module eq_gain_regs
    import eq_pkg::*;
#(
    parameter int GAIN_W   = 5,
    parameter int GAIN_LIM = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [EQ_BAND_W-1:0]     addr,
    input  logic signed [GAIN_W-1:0] wdata,
    input  logic                     load,
    output logic signed [GAIN_W-1:0] act [EQ_BANDS]
);

    localparam logic signed [GAIN_W-1:0] LIM_P = GAIN_W'(GAIN_LIM);
    localparam logic signed [GAIN_W-1:0] LIM_N = GAIN_W'(-GAIN_LIM);

    logic signed [GAIN_W-1:0] wclamp;

    // Limit the written gain to the table range
    always_comb begin
        if (wdata > LIM_P)      wclamp = LIM_P;
        else if (wdata < LIM_N) wclamp = LIM_N;
        else                    wclamp = wdata;
    end

    for (genvar b = 0; b < EQ_BANDS; b++) begin : g_band
        logic signed [GAIN_W-1:0] shadow_q;
        logic signed [GAIN_W-1:0] active_q;

        // Capture software writes into the shadow copy
        always_ff @(posedge clk) begin
            if (!rst_n)                                 shadow_q <= '0;
            else if (we && addr == EQ_BAND_W'(b))       shadow_q <= wclamp;
        end

        // Move the shadow gain into use when a sample is accepted
        always_ff @(posedge clk) begin
            if (!rst_n)     active_q <= '0;
            else if (load)  active_q <= shadow_q;
        end

        assign act[b] = active_q;
    end

endmodule

// File: rtl/eq_coef_rom.sv
// Built-in coefficient table indexed by band, gain+GAIN_LIM and tap.
// Entries are computed at elaboration from the formula in eq_pkg.
// Assumes gain lies within +/-GAIN_LIM.
module eq_coef_rom
    import eq_pkg::*;
#(
    parameter int COEF_W   = 16,
    parameter int FRAC     = 14,
    parameter int GAIN_W   = 5,
    parameter int GAIN_LIM = 9
) (
    input  logic [EQ_BAND_W-1:0]      band,
    input  logic signed [GAIN_W-1:0]  gain,
    input  logic [EQ_TAP_W-1:0]       tap,
    output logic signed [COEF_W-1:0]  coef
);

    localparam int N_GAIN = 2 * GAIN_LIM + 1;
    localparam int GIDX_W = $clog2(N_GAIN);

    logic signed [COEF_W-1:0] tbl [EQ_BANDS][N_GAIN][EQ_TAPS];
    logic [GIDX_W-1:0]        gidx;

    for (genvar b = 0; b < EQ_BANDS; b++) begin : g_b
        for (genvar i = 0; i < N_GAIN; i++) begin : g_i
            for (genvar t = 0; t < EQ_TAPS; t++) begin : g_t
                assign tbl[b][i][t] = COEF_W'(coef_val(b, i - GAIN_LIM, t, 1 << FRAC));
            end
        end
    end

    // Offset the signed gain into a table row and read the tap
    always_comb begin
        gidx = GIDX_W'(int'(gain) + GAIN_LIM);
        coef = tbl[band][gidx][tap];
    end

endmodule

// File: rtl/eq_mac.sv
// Shared signed multiply-accumulate with saturating Q-format result.
// The result output reflects the accumulator including this cycle's product.
// Assumes ACC_W is wide enough for five full-scale products.
module eq_mac #(
    parameter int SAMP_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 36,
    parameter int FRAC   = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     clr,
    input  logic                     sub,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [SAMP_W-1:0] opnd,
    output logic signed [SAMP_W-1:0] y_sat
);

    localparam int PROD_W = SAMP_W + COEF_W;
    localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) <<< (SAMP_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_x;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_d;
    logic signed [ACC_W-1:0]  scaled;

    // Form the product and fold it into the running sum
    always_comb begin
        prod   = coef * opnd;
        prod_x = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
        acc_d  = sub ? (acc_q - prod_x) : (acc_q + prod_x);
        scaled = acc_d >>> FRAC;
    end

    // Hold the partial sum between taps, empty it after the last tap
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (en)     acc_q <= acc_d;
    end

    // Clip the scaled sum to the sample range
    always_comb begin
        if (scaled > SAT_HI)      y_sat = SAT_HI[SAMP_W-1:0];
        else if (scaled < SAT_LO) y_sat = SAT_LO[SAMP_W-1:0];
        else                      y_sat = scaled[SAMP_W-1:0];
    end

endmodule

// File: rtl/eq_sect_state.sv
// Direct form I history (two past inputs, two past outputs) for each section,
// and the operand mux that feeds the shared multiplier.
// Assumes upd pulses once per section, on its last tap.
module eq_sect_state
    import eq_pkg::*;
#(
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic [EQ_BAND_W-1:0]     sec,
    input  logic [EQ_TAP_W-1:0]      tap,
    input  logic signed [SAMP_W-1:0] x_in,
    input  logic signed [SAMP_W-1:0] y_in,
    output logic signed [SAMP_W-1:0] opnd
);

    logic signed [SAMP_W-1:0] x1_a [EQ_BANDS];
    logic signed [SAMP_W-1:0] x2_a [EQ_BANDS];
    logic signed [SAMP_W-1:0] y1_a [EQ_BANDS];
    logic signed [SAMP_W-1:0] y2_a [EQ_BANDS];

    for (genvar s = 0; s < EQ_BANDS; s++) begin : g_sec
        logic signed [SAMP_W-1:0] x1_r, x2_r, y1_r, y2_r;

        // Shift this section's history when its result retires
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                x1_r <= '0;
                x2_r <= '0;
                y1_r <= '0;
                y2_r <= '0;
            end else if (upd && sec == EQ_BAND_W'(s)) begin
                x2_r <= x1_r;
                x1_r <= x_in;
                y2_r <= y1_r;
                y1_r <= y_in;
            end
        end

        assign x1_a[s] = x1_r;
        assign x2_a[s] = x2_r;
        assign y1_a[s] = y1_r;
        assign y2_a[s] = y2_r;
    end

    // Pick the sample that pairs with the current tap
    always_comb begin
        case (int'(tap))
            0:       opnd = x_in;
            1:       opnd = x1_a[sec];
            2:       opnd = x2_a[sec];
            3:       opnd = y1_a[sec];
            default: opnd = y2_a[sec];
        endcase
    end

endmodule

// File: rtl/eq_ctrl.sv
// Sequencer: accepts a sample when idle, then steps tap 0..4 of
// section 0..3, one tap per cycle, and flags the final tap.
// Assumes samples arrive far less often than once per 20 cycles.
module eq_ctrl
    import eq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 busy,
    output logic                 accept,
    output logic [EQ_BAND_W-1:0] sec,
    output logic [EQ_TAP_W-1:0]  tap,
    output logic                 sub,
    output logic                 last_tap,
    output logic                 done
);

    eq_state_e state_q;

    // Decode the current step
    always_comb begin
        busy     = (state_q == EQ_RUN);
        accept   = (state_q == EQ_IDLE) && in_valid;
        last_tap = busy && (tap == EQ_TAP_W'(EQ_TAPS - 1));
        done     = last_tap && (sec == EQ_BAND_W'(EQ_BANDS - 1));
        sub      = (tap >= EQ_TAP_W'(3));
    end

    // Advance state, section and tap counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EQ_IDLE;
            sec     <= '0;
            tap     <= '0;
        end else if (accept) begin
            state_q <= EQ_RUN;
            sec     <= '0;
            tap     <= '0;
        end else if (busy) begin
            if (last_tap) begin
                tap <= '0;
                if (done) begin
                    state_q <= EQ_IDLE;
                    sec     <= '0;
                end else begin
                    sec <= sec + EQ_BAND_W'(1);
                end
            end else begin
                tap <= tap + EQ_TAP_W'(1);
            end
        end
    end

endmodule

// File: rtl/biquad_eq_top.sv
// Four-band gain-indexed biquad equalizer with one shared MAC.
// Each sample runs through bands 0..3 in series; a result strobe follows
// 20 cycles after acceptance. Assumes a sample period well above 20 cycles.
module biquad_eq_top
    import eq_pkg::*;
#(
    parameter int IN_W      = 12,
    parameter int SAMP_W    = 16,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 14,
    parameter int ACC_W     = 36,
    parameter int GAIN_W    = 5,
    parameter int GAIN_LIM  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [IN_W-1:0]      in_data,
    output logic                 out_valid,
    output logic [SAMP_W-1:0]    out_data,
    input  logic                 reg_we,
    input  logic [EQ_BAND_W-1:0] reg_addr,
    input  logic [GAIN_W-1:0]    reg_wdata
);

    logic                     busy, accept, sub, last_tap, done;
    logic [EQ_BAND_W-1:0]     sec;
    logic [EQ_TAP_W-1:0]      tap;
    logic signed [GAIN_W-1:0] act [EQ_BANDS];
    logic [EQ_BANDS*GAIN_W-1:0] act_flat;
    logic signed [COEF_W-1:0] coef;
    logic signed [SAMP_W-1:0] opnd, y_sat, cur_x;

    eq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .busy(busy), .accept(accept), .sec(sec), .tap(tap),
        .sub(sub), .last_tap(last_tap), .done(done)
    );

    eq_gain_regs #(.GAIN_W(GAIN_W), .GAIN_LIM(GAIN_LIM)) u_gain (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata($signed(reg_wdata)), .load(accept), .act(act)
    );

    for (genvar b = 0; b < EQ_BANDS; b++) begin : g_flat
        assign act_flat[b*GAIN_W +: GAIN_W] = act[b];
    end

    eq_coef_rom #(.COEF_W(COEF_W), .FRAC(COEF_FRAC), .GAIN_W(GAIN_W), .GAIN_LIM(GAIN_LIM)) u_rom (
        .band(sec), .gain(act[sec]), .tap(tap), .coef(coef)
    );

    eq_sect_state #(.SAMP_W(SAMP_W)) u_state (
        .clk(clk), .rst_n(rst_n), .upd(last_tap), .sec(sec), .tap(tap),
        .x_in(cur_x), .y_in(y_sat), .opnd(opnd)
    );

    eq_mac #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(COEF_FRAC)) u_mac (
        .clk(clk), .rst_n(rst_n), .en(busy), .clr(last_tap), .sub(sub),
        .coef(coef), .opnd(opnd), .y_sat(y_sat)
    );

    // Hold the input of the section being evaluated
    always_ff @(posedge clk) begin
        if (!rst_n)                 cur_x <= '0;
        else if (accept)            cur_x <= {{(SAMP_W - IN_W){in_data[IN_W-1]}}, in_data};
        else if (last_tap && !done) cur_x <= y_sat;
    end

    // Register the final section's result and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= done;
            if (done) out_data <= y_sat;
        end
    end

endmodule

// File: rtl/eq_chk.sv
// Protocol checks for biquad_eq_top, attached with bind.
// Assumes busy is high exactly while a sample is being processed.
module eq_chk
    import eq_pkg::*;
#(
    parameter int GAIN_W   = 5,
    parameter int GAIN_LIM = 9
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       busy,
    input logic                       out_valid,
    input logic [EQ_BANDS*GAIN_W-1:0] act_flat
);

    localparam int LAT = EQ_BANDS * EQ_TAPS;

    logic [7:0] lat_q;

    // Count edges since the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n)                   lat_q <= '0;
        else if (in_valid && !busy)   lat_q <= '0;
        else if (busy)                lat_q <= lat_q + 8'd1;
    end

    function automatic logic gains_ok(input logic [EQ_BANDS*GAIN_W-1:0] f);
        gains_ok = 1'b1;
        for (int b = 0; b < EQ_BANDS; b++) begin
            if ($signed(f[b*GAIN_W +: GAIN_W]) > GAIN_LIM ||
                $signed(f[b*GAIN_W +: GAIN_W]) < -GAIN_LIM)
                gains_ok = 1'b0;
        end
    endfunction

    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lat_q == 8'(LAT));

    // R8
    out_after_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));

    // R9
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(act_flat));

    // R2
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gains_ok(act_flat));

endmodule

bind biquad_eq_top eq_chk #(.GAIN_W(GAIN_W), .GAIN_LIM(GAIN_LIM)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
    .out_valid(out_valid), .act_flat(act_flat)
);

// File: tb/biquad_eq_top_test.sv
`timescale 1ns/1ps
module biquad_eq_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [4:0]  reg_wdata = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // Band constants from R3
    int PA[4] = '{-30364, -21917, -5291, 18127};
    int QA[4] = '{15416, 15099, 14787, 14477};
    int SA[4] = '{1000, 800, 600, 500};

    int     g_sh[4];
    int     g_act[4];
    longint mx1[4], mx2[4], my1[4], my2[4];

    biquad_eq_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampg(input int g);
        if (g > 9) return 9;
        if (g < -9) return -9;
        return g;
    endfunction

    function automatic longint mcoef(input int b, input int g, input int t);
        longint d;
        d = longint'(g) * SA[b];
        case (t)
            0:       return 16384 + d;
            1:       return PA[b];
            2:       return QA[b] - d;
            3:       return PA[b];
            default: return QA[b];
        endcase
    endfunction

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // R4/R5 reference: four direct form I sections in series
    function automatic longint model_step(input longint xin);
        longint x, acc, y;
        x = xin;
        for (int s = 0; s < 4; s++) begin
            acc = mcoef(s, g_act[s], 0) * x + mcoef(s, g_act[s], 1) * mx1[s]
                + mcoef(s, g_act[s], 2) * mx2[s] - mcoef(s, g_act[s], 3) * my1[s]
                - mcoef(s, g_act[s], 4) * my2[s];
            y = sat16(acc >>> 14);
            mx2[s] = mx1[s]; mx1[s] = x;
            my2[s] = my1[s]; my1[s] = y;
            x = y;
        end
        return x;
    endfunction

    function automatic void model_clear();
        for (int b = 0; b < 4; b++) begin
            g_sh[b] = 0; g_act[b] = 0;
            mx1[b] = 0; mx2[b] = 0; my1[b] = 0; my2[b] = 0;
        end
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
        chk(out_data == 16'd0, "R10 reset out_data", out_data, 0);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic wr(input int b, input int g);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'(b); reg_wdata = 5'(g);
        @(negedge clk);
        reg_we = 1'b0;
        g_sh[b] = clampg(g);
    endtask

    task automatic send(input int x, input bit mid_wr, input int wb, input int wg,
                        input bit stray, input string req, output longint got_v);
        longint exp;
        int     n;
        bit     got;
        int     extra;
        @(negedge clk);
        in_valid = 1'b1; in_data = 12'(x);
        for (int b = 0; b < 4; b++) g_act[b] = g_sh[b];
        exp = model_step(longint'(x));
        @(negedge clk);
        in_valid = 1'b0;
        n = 0; got = 1'b0;
        while (!got && n < 40) begin
            if (mid_wr && n == 4) begin reg_we = 1'b1; reg_addr = 2'(wb); reg_wdata = 5'(wg); end
            if (mid_wr && n == 5) begin reg_we = 1'b0; g_sh[wb] = clampg(wg); end
            if (stray && n == 7) in_valid = 1'b1;
            if (stray && n == 8) in_valid = 1'b0;
            @(negedge clk);
            n++;
            if (out_valid) got = 1'b1;
        end
        got_v = longint'($signed(out_data));
        chk(got && n == 20, "R7 latency", n, 20);
        chk(got_v == exp, req, got_v, exp);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 single pulse", out_valid, 0);
        if (stray) begin
            extra = 0;
            repeat (25) begin
                @(negedge clk);
                if (out_valid) extra++;
            end
            chk(extra == 0, "R8 stray strobe ignored", extra, 0);
        end
    endtask

    initial begin
        longint r;
        int     nsat;
        model_clear();
        do_reset();

        // R6 / R1: exhaustive-ish flat sweep with zero history
        for (int x = -2048; x <= 2047; x += 37) begin
            send(x, 0, 0, 0, 0, "R6 flat model", r);
            chk(r == x, "R6 R1 flat identity", r, x);
        end
        send(2047, 0, 0, 0, 0, "R1 max positive", r);
        chk(r == 2047, "R1 sign extension max", r, 2047);
        send(-2048, 0, 0, 0, 0, "R1 max negative", r);
        chk(r == -2048, "R1 sign extension min", r, -2048);

        // R3 R4 R5: every gain row of every band, impulse plus tail
        for (int b = 0; b < 4; b++) begin
            for (int g = -9; g <= 9; g++) begin
                wr(b, g);
                send(1500, 0, 0, 0, 0, $sformatf("R3 R4 R5 band%0d gain%0d imp", b, g), r);
                send(-700, 0, 0, 0, 0, $sformatf("R3 R4 R5 band%0d gain%0d t1", b, g), r);
                send(0,    0, 0, 0, 0, $sformatf("R3 R4 R5 band%0d gain%0d t2", b, g), r);
                send(300,  0, 0, 0, 0, $sformatf("R3 R4 R5 band%0d gain%0d t3", b, g), r);
            end
            wr(b, 0);
        end

        // R2: out-of-range writes clamp to +/-9
        wr(1, 15);
        send(1200, 0, 0, 0, 0, "R2 clamp high", r);
        send(-300, 0, 0, 0, 0, "R2 clamp high tail", r);
        wr(1, -16);
        send(1200, 0, 0, 0, 0, "R2 clamp low", r);
        send(-300, 0, 0, 0, 0, "R2 clamp low tail", r);
        wr(1, 0);

        // R9: write during processing applies to the next sample only
        send(800, 1, 2, 7, 0, "R9 write mid-sample", r);
        send(-400, 0, 0, 0, 0, "R9 new gain next sample", r);
        send(250, 1, 0, -5, 0, "R9 second write mid-sample", r);
        send(100, 0, 0, 0, 0, "R9 history kept", r);

        // R8: strobe during processing is dropped
        send(600, 0, 0, 0, 1, "R8 result unaffected", r);
        send(-900, 0, 0, 0, 0, "R8 later result unaffected", r);

        // R11: all bands at +9 dB driven by a resonant square wave
        for (int b = 0; b < 4; b++) wr(b, 9);
        nsat = 0;
        for (int k = 0; k < 63; k++) begin
            send(((k % 21) < 10) ? 2047 : -2048, 0, 0, 0, 0, "R11 saturating model", r);
            if (r == 32767 || r == -32768) nsat++;
        end
        chk(nsat > 0, "R11 saturation reached", nsat, 1);

        // R10: reset mid-stream clears gains and history
        do_reset();
        send(1000, 0, 0, 0, 0, "R10 after reset", r);
        chk(r == 1000, "R10 gains and state cleared", r, 1000);
        send(-1500, 0, 0, 0, 0, "R10 after reset 2", r);
        chk(r == -1500, "R10 gains and state cleared 2", r, -1500);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule